// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of a classic programmable interval timer. A register front end writes a counting mode (with a BCD flag that is only stored for status) and then an initial count. The channel counts on the cycles where its clock-enable input is high. It drives an output pin whose waveform depends on the mode: a one-shot level change, a strobe at terminal count, a periodic rate pulse, or a square wave.

A gate input either suspends counting or retriggers the channel, depending on the mode. The current count is exposed continuously so that a latch outside the block can capture it. The output level is available to a status path. An initial count of zero stands for 65536.

Counting modes, by the 3-bit code written on `mode_val`: 0 is a one-shot that goes high at terminal count, and 1 is the gate-retriggered form of 0. 2 is the periodic rate generator and 3 is the periodic square wave. 4 is a single low strobe, and 5 is the gate-retriggered form of 4. Codes 6 and 7 are stored as 2 and 3.

Top module: `ivl_chan`

## Requirements
- R1: A count write of 0 acts as 65536. In mode 0, `count_q` reads 0 after the write and 65535 after the first tick. `out_pin` stays low until the 65536th tick and goes high on it.
- R2: In modes 0 and 1, a count write drives `out_pin` low. The count then drops by one per tick. `out_pin` goes high on the tick that brings the count to 0 and stays high. The count wraps from 0 to 65535 with no reload.
- R3: In modes 4 and 5, `out_pin` is high after a count write. On the tick that brings the count to 0 it goes low, and it returns high on the next tick. The count wraps without reload and there is no second strobe before a restart.
- R4: In mode 2, with initial count N ≥ 2, the count runs N, N-1, …, 1 and then reloads N. `out_pin` is low exactly while the count is 1, which gives a period of N ticks.
- R5: In mode 3, with initial count N ≥ 2, the count drops by two per tick. `out_pin` is high for ceil(N/2) ticks, starting at N, then low for floor(N/2) ticks, starting at N rounded down to even. It then repeats.
- R6: In modes 0, 2, 3 and 4, a low `gate_in` stops counting. In modes 2 and 3, a low gate also drives `out_pin` high on the next clock edge.
- R7: In modes 1, 2, 3 and 5, once a count has been written, a rising edge on `gate_in` reloads the initial count on that clock edge. `out_pin` returns to the level it has just after a count write.
- R8: In modes 0 and 4, a rising edge on `gate_in` causes no reload. Counting resumes from the held value.
- R9: With `cnt_en` low, and with no write and no retrigger, `count_q` holds its value.
- R10: A mode write stops the channel until the next count write and stores `bcd_val` on `bcd_q`. It drives `out_pin` low for codes 0 and 1 and high for all other codes. Codes 6 and 7 behave as 2 and 3.
- R11: After reset the channel is in mode 0 and idle, with `out_pin` low, `count_q` 0 and `bcd_q` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count clock enable (one tick per high cycle) |
| gate_in | input | 1 | Gate: enable or retrigger, depending on the mode |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 3 | Mode code written by a mode write |
| bcd_val | input | 1 | BCD flag written by a mode write |
| load_wr | input | 1 | Initial-count write strobe |
| load_val | input | 16 | Initial count (0 means 65536) |
| out_pin | output | 1 | Channel output waveform |
| count_q | output | 16 | Current count, for an external latch |
| bcd_q | output | 1 | Stored BCD flag, for status |

## Verification
The main function is swept over every initial count from 1 or 2 up to 20 in modes 0, 2, 3 and 4. Each run covers more than two periods, and the count and output level are compared every tick against closed-form expressions of the tick number. Even and odd counts in mode 3 separate a correct split of the half periods from an off-by-one. A full 65536-tick run with a zero count separates the 65536 reading from a zero-length count. Gate patterns (held low, then raised, in each mode family) separate suspend from retrigger. Codes 6 and 7 are replayed against the mode 2 and 3 expectations.

// File: rtl/ivl_chan.sv
module ivl_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         gate_in,
  input  logic         mode_wr,
  input  logic [2:0]   mode_val,
  input  logic         bcd_val,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  output logic         out_pin,
  output logic [W-1:0] count_q,
  output logic         bcd_q
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [2:0]   mode_q;
  logic [W-1:0] init_q;
  logic         armed_q, done_q, gate_q;

  function automatic logic start_lvl(input logic [2:0] m);
    return m[2:1] != 2'b00;
  endfunction

  wire [2:0]   mode_n   = mode_val[1] ? {1'b0, mode_val[1:0]} : mode_val;
  wire         periodic = mode_q[1];
  wire         edge_trg = (mode_q == 3'd1) || (mode_q == 3'd5);
  wire         gate_ok  = edge_trg | gate_in;
  wire         gate_rise = gate_in & ~gate_q;
  wire         tick     = cnt_en & armed_q & gate_ok;
  wire [W-1:0] dec1     = count_q - ONE;
  wire [W-1:0] dec2     = count_q - TWO;
  wire [W-1:0] nxt2     = (count_q == ONE) ? init_q : dec1;
  wire [W-1:0] low_init = {init_q[W-1:1], 1'b0};
  wire         half_end = (count_q == ONE) || (count_q == TWO);

  always_ff @(posedge clk) begin
    gate_q <= gate_in;
    if (!rst_n) begin
      mode_q  <= 3'd0;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      count_q <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      out_pin <= 1'b0;
    end else if (mode_wr) begin
      mode_q  <= mode_n;
      bcd_q   <= bcd_val;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      out_pin <= start_lvl(mode_n);
    end else if (load_wr) begin
      init_q  <= load_val;
      count_q <= load_val;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      out_pin <= start_lvl(mode_q);
    end else if (gate_rise && armed_q && (edge_trg || periodic)) begin
      count_q <= init_q;
      done_q  <= 1'b0;
      out_pin <= start_lvl(mode_q);
    end else if (periodic && !gate_in) begin
      out_pin <= 1'b1;
    end else if (tick) begin
      case (mode_q)
        3'd2: begin
          count_q <= nxt2;
          out_pin <= (nxt2 != ONE);
        end
        3'd3: begin
          if (half_end) begin
            out_pin <= ~out_pin;
            count_q <= out_pin ? low_init : init_q;
          end else begin
            count_q <= dec2;
          end
        end
        3'd4, 3'd5: begin
          count_q <= dec1;
          if (count_q == ONE && !done_q) begin
            out_pin <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            out_pin <= 1'b1;
          end
        end
        default: begin
          count_q <= dec1;
          if (count_q == ONE) out_pin <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ivl_chan_chk.sv
module ivl_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         gate_in,
  input logic         mode_wr,
  input logic         load_wr,
  input logic [W-1:0] load_val,
  input logic [2:0]   mode_q,
  input logic         out_pin,
  input logic [W-1:0] count_q
);
  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && !mode_wr) |=> (count_q == $past(load_val))); // R1

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_wr && !mode_wr && !(gate_in && !$past(gate_in))) |=> $stable(count_q)); // R9

  AST_M0_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && $rose(out_pin)) |-> (count_q == '0)); // R2

  AST_M2_LOW_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !out_pin) |-> (count_q == W'(1))); // R4

  AST_GATE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q[1] && !gate_in && !mode_wr) && mode_q[1]) |-> out_pin); // R6
endmodule

bind ivl_chan ivl_chan_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate_in(gate_in),
  .mode_wr(mode_wr), .load_wr(load_wr), .load_val(load_val),
  .mode_q(mode_q), .out_pin(out_pin), .count_q(count_q)
);

// File: tb/ivl_chan_tb_top.sv
`timescale 1ns/1ps
module ivl_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b1, gate_in = 1'b1, mode_wr = 1'b0, bcd_val = 1'b0, load_wr = 1'b0;
  logic [2:0] mode_val = 3'd0;
  logic [15:0] load_val = 16'd0;
  logic out_pin, bcd_q;
  logic [15:0] count_q;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ivl_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate_in(gate_in),
    .mode_wr(mode_wr), .mode_val(mode_val), .bcd_val(bcd_val),
    .load_wr(load_wr), .load_val(load_val),
    .out_pin(out_pin), .count_q(count_q), .bcd_q(bcd_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input int m, input bit b);
    mode_wr = 1'b1; mode_val = 3'(m); bcd_val = b;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr_load(input int n);
    load_wr = 1'b1; load_val = 16'(n);
    @(negedge clk);
    load_wr = 1'b0;
  endtask

  function automatic int exp_cnt(input int m, input int n, input int k);
    int np = (n == 0) ? 65536 : n;
    int p = k % np;
    int h = (np + 1) / 2;
    case (m)
      2: return (np - p) & 16'hFFFF;
      3: return (p < h) ? ((np - 2 * p) & 16'hFFFF) : (((np & ~1) - 2 * (p - h)) & 16'hFFFF);
      default: return (n - k) & 16'hFFFF;
    endcase
  endfunction

  function automatic int exp_out(input int m, input int n, input int k);
    int np = (n == 0) ? 65536 : n;
    int p = k % np;
    case (m)
      0, 1: return int'(k >= np);
      2: return int'(p != np - 1);
      3: return int'(p < (np + 1) / 2);
      default: return int'(k != np);
    endcase
  endfunction

  task automatic sweep(input string tag, input int m_wr, input int m_exp, input int n, input int ticks);
    wr_mode(m_wr, 1'b0);
    wr_load(n);
    for (int k = 0; k <= ticks; k++) begin
      if (k > 0) @(negedge clk);
      chk({tag, " count"}, count_q, exp_cnt(m_exp, n, k));
      chk({tag, " out"}, out_pin, exp_out(m_exp, n, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state and idle
    chk("R11 out", out_pin, 0);
    chk("R11 count", count_q, 0);
    chk("R11 bcd", bcd_q, 0);
    tick_n(3);
    chk("R11 idle count", count_q, 0);

    for (int n = 1; n <= 20; n++) sweep("R2 mode0", 0, 0, n, 2 * n + 2);
    for (int n = 1; n <= 20; n++) sweep("R3 mode4", 4, 4, n, 2 * n + 2);
    for (int n = 2; n <= 20; n++) sweep("R4 mode2", 2, 2, n, 2 * n + 2);
    for (int n = 2; n <= 20; n++) sweep("R5 mode3", 3, 3, n, 2 * n + 2);
    sweep("R2 mode1", 1, 1, 7, 12);
    sweep("R3 mode5", 5, 5, 6, 12);
    sweep("R10 code6", 6, 2, 5, 12);
    sweep("R10 code7", 7, 3, 7, 16);

    // R1 zero means 65536
    wr_mode(0, 1'b0);
    wr_load(0);
    chk("R1 count k0", count_q, 0);
    @(negedge clk);
    chk("R1 count k1", count_q, 65535);
    tick_n(65534);
    chk("R1 count k65535", count_q, 1);
    chk("R1 out k65535", out_pin, 0);
    @(negedge clk);
    chk("R1 count k65536", count_q, 0);
    chk("R1 out k65536", out_pin, 1);

    // R9 enable low holds
    wr_mode(0, 1'b0);
    wr_load(20);
    cnt_en = 1'b0;
    tick_n(4);
    chk("R9 held", count_q, 20);
    cnt_en = 1'b1;
    tick_n(3);
    chk("R9 resumed", count_q, 17);

    // R6 / R8 mode 0 gate suspend, no reload on rise
    wr_load(10);
    tick_n(3);
    gate_in = 1'b0;
    tick_n(4);
    chk("R6 mode0 held count", count_q, 7);
    chk("R6 mode0 held out", out_pin, 0);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R8 mode0 no reload", count_q, 6);
    tick_n(6);
    chk("R8 mode0 count", count_q, 0);
    chk("R8 mode0 out", out_pin, 1);

    // R8 mode 4
    wr_mode(4, 1'b0);
    wr_load(9);
    tick_n(2);
    gate_in = 1'b0;
    tick_n(2);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R8 mode4 no reload", count_q, 6);

    // R6 / R7 mode 2
    wr_mode(2, 1'b0);
    wr_load(5);
    tick_n(4);
    chk("R4 mode2 at one", out_pin, 0);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R6 mode2 forced out", out_pin, 1);
    chk("R6 mode2 held count", count_q, 1);
    @(negedge clk);
    chk("R6 mode2 still held", count_q, 1);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R7 mode2 reload", count_q, 5);
    chk("R7 mode2 out", out_pin, 1);
    tick_n(4);
    chk("R7 mode2 pulse", out_pin, 0);
    @(negedge clk);
    chk("R7 mode2 period", count_q, 5);

    // R6 / R7 mode 3
    wr_mode(3, 1'b0);
    wr_load(6);
    tick_n(4);
    chk("R5 mode3 low half", out_pin, 0);
    chk("R5 mode3 low count", count_q, 4);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R6 mode3 forced out", out_pin, 1);
    chk("R6 mode3 held count", count_q, 4);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R7 mode3 reload", count_q, 6);

    // R7 mode 1 retrigger
    wr_mode(1, 1'b0);
    wr_load(8);
    tick_n(5);
    chk("R2 mode1 count", count_q, 3);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R7 mode1 gate low counts", count_q, 2);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R7 mode1 reload", count_q, 8);
    chk("R7 mode1 out low", out_pin, 0);
    tick_n(7);
    chk("R7 mode1 before end", out_pin, 0);
    @(negedge clk);
    chk("R7 mode1 end", out_pin, 1);
    gate_in = 1'b0;
    @(negedge clk);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R7 mode1 retrigger low", out_pin, 0);
    chk("R7 mode1 retrigger count", count_q, 8);

    // R7 mode 5 retrigger
    wr_mode(5, 1'b0);
    wr_load(3);
    tick_n(3);
    chk("R3 mode5 strobe", out_pin, 0);
    tick_n(1);
    chk("R3 mode5 after", out_pin, 1);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R3 mode5 no second", out_pin, 1);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R7 mode5 reload", count_q, 3);
    tick_n(3);
    chk("R7 mode5 second strobe", out_pin, 0);

    // R10 mode write halts, bcd stored
    wr_mode(3, 1'b1);
    chk("R10 bcd set", bcd_q, 1);
    chk("R10 mode3 out", out_pin, 1);
    wr_load(9);
    tick_n(2);
    chk("R10 running", count_q, 5);
    wr_mode(0, 1'b0);
    chk("R10 mode0 out", out_pin, 0);
    chk("R10 bcd clear", bcd_q, 0);
    tick_n(3);
    chk("R10 halted", count_q, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule